// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Triggered Commit

This block turns a free-running input clock into a stream of single-cycle enable pulses whose average rate is the input rate divided first by a fixed integer pre-divider and then by a programmable fixed-point divisor. The divisor has `FIELD_W` bits, of which the low `FRAC_W` bits are fractional. The stored field is biased so that the divisor actually applied, counted in units of 2^-FRAC_W, is the field value plus 2^FRAC_W. A field of zero therefore divides by exactly 1.0, and the encoding cannot express anything smaller. Pulses come from a phase accumulator: every prescaler tick adds one unit to the phase, and a pulse is issued whenever the phase reaches the divisor.

Software stages a new divisor through a single register and arms a self-clearing trigger bit. The running divisor stays in force until the next output pulse. At that pulse the staged value becomes active, the phase restarts from zero and the trigger bit clears. No shortened period can appear around the change. A gate input stops the whole divider, so a trigger armed while the gate is closed stays pending.

Top module: `fracdiv_trig`

## Requirements
- R1: After reset `clk_en_o` is 0, the trigger bit reads 0 and the field reads `INIT_FIELD`.
- R2: With committed field f, D = f + 2^FRAC_W. Counting prescaler ticks t and pulses p since the last commit or reset, the tick that first makes t*2^FRAC_W >= (p+1)*D issues a pulse on `clk_en_o` one cycle later.
- R3: A field of 0 gives a pulse on every prescaler tick (divide by 1.0).
- R4: An all-ones field gives a divisor of (2^FIELD_W - 1 + 2^FRAC_W) / 2^FRAC_W.
- R5: A write updates only bits [FIELD_LSB +: FIELD_W] and the trigger bit `TRIG_BIT` (bit 0 by default). All other written bits have no effect and read as 0.
- R6: `rd_data` shows the committed field. A staged value that has not been triggered does not change the readback or the pulse rate.
- R7: Writing 1 to the trigger bit sets it. It reads 1 until the next output pulse. At the edge that raises that pulse, the staged field is committed, the trigger bit clears and the phase restarts from zero.
- R8: While `gate_open` is 0, no pulse is produced, the prescaler and phase hold, and a pending trigger stays pending.
- R9: While the trigger is pending, writes are ignored, including their field bits.
- R10: Prescaler ticks occur on every `PRE_DIV`-th cycle in which `gate_open` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_open | input | 1 | Divider runs while 1 |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | REG_W | Register write data |
| rd_data | output | REG_W | Committed field and trigger status |
| clk_en_o | output | 1 | Output clock-enable pulse |

## Verification
A corrupted phase accumulator or prescaler count shows as a pulse on `clk_en_o` that lands one tick early or late. That error appears within one divisor period and is caught at the very next pulse. A wrong commit shows in `rd_data` at the edge where the trigger bit should fall. The trigger bit either clears without a pulse on that edge, or the field changes to the wrong value. A lost pending state shows as a trigger bit that never clears, or one that clears while the gate is closed.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

    typedef enum logic {
        TRG_IDLE = 1'b0,
        TRG_WAIT = 1'b1
    } trg_state_e;

    typedef struct packed {
        logic tick;
        logic fire;
    } phase_evt_t;

    function automatic int unsigned phase_width(int unsigned field_w);
        return field_w + 2;
    endfunction

endpackage

// File: rtl/fracdiv_prescale.sv
module fracdiv_prescale #(
    parameter int unsigned PRE_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_open,
    output logic tick
);
    localparam int unsigned CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = gate_open && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (gate_open) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assert_tick_needs_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !gate_open |=> $stable(cnt_q));

endmodule

// File: rtl/fracdiv_accum.sv
module fracdiv_accum
    import fracdiv_pkg::*;
#(
    parameter int unsigned FIELD_W = 6,
    parameter int unsigned FRAC_W  = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               restart,
    input  logic [FIELD_W-1:0] div_field,
    output phase_evt_t         evt,
    output logic               en_q
);
    localparam int unsigned AW = phase_width(FIELD_W);
    localparam logic [AW-1:0] ONE = AW'(1) << FRAC_W;

    logic [AW-1:0] acc_q;
    logic [AW-1:0] div_s;
    logic [AW-1:0] sum;

    assign div_s    = AW'(div_field) + ONE;
    assign sum      = acc_q + ONE;
    assign evt.tick = tick;
    assign evt.fire = tick && (sum >= div_s);

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= evt.fire;
            if (tick) begin
                if (evt.fire) begin
                    acc_q <= restart ? '0 : sum - div_s;
                end else begin
                    acc_q <= sum;
                end
            end
        end
    end

    assert_phase_below_divisor_R2: assert property (@(posedge clk) disable iff (rst)
        acc_q < div_s);

    assert_unit_divisor_R3: assert property (@(posedge clk) disable iff (rst)
        (div_field == '0 && tick) |=> en_q);

endmodule

// File: rtl/fracdiv_ctrl.sv
module fracdiv_ctrl
    import fracdiv_pkg::*;
#(
    parameter int unsigned REG_W      = 32,
    parameter int unsigned FIELD_LSB  = 8,
    parameter int unsigned FIELD_W    = 6,
    parameter int unsigned TRIG_BIT   = 0,
    parameter int unsigned INIT_FIELD = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               fire,
    output logic [FIELD_W-1:0] cur_field,
    output logic               pending,
    output logic [REG_W-1:0]   rd_data
);
    trg_state_e         state_q;
    logic [FIELD_W-1:0] cur_q;
    logic [FIELD_W-1:0] stage_q;
    logic               unused_wr_bits;

    assign unused_wr_bits = ^wr_data;
    assign cur_field      = cur_q;
    assign pending        = (state_q == TRG_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRG_IDLE;
            cur_q   <= FIELD_W'(INIT_FIELD);
            stage_q <= FIELD_W'(INIT_FIELD);
        end else if (state_q == TRG_WAIT) begin
            if (fire) begin
                cur_q   <= stage_q;
                state_q <= TRG_IDLE;
            end
        end else if (wr_en) begin
            stage_q <= wr_data[FIELD_LSB +: FIELD_W];
            if (wr_data[TRIG_BIT]) begin
                state_q <= TRG_WAIT;
            end
        end
    end

    always_comb begin
        rd_data                       = '0;
        rd_data[FIELD_LSB +: FIELD_W] = cur_q;
        rd_data[TRIG_BIT]             = pending;
    end

    assert_commit_only_at_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        !(pending && fire) |=> $stable(cur_q));

    assert_pending_held_R8: assert property (@(posedge clk) disable iff (rst)
        (pending && !fire) |=> pending);

    assert_stage_frozen_R9: assert property (@(posedge clk) disable iff (rst)
        pending |=> $stable(stage_q));

endmodule

// File: rtl/fracdiv_trig.sv
module fracdiv_trig
    import fracdiv_pkg::*;
#(
    parameter int unsigned REG_W      = 32,
    parameter int unsigned FIELD_LSB  = 8,
    parameter int unsigned FIELD_W    = 6,
    parameter int unsigned FRAC_W     = 2,
    parameter int unsigned TRIG_BIT   = 0,
    parameter int unsigned PRE_DIV    = 2,
    parameter int unsigned INIT_FIELD = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_open,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             clk_en_o
);
    logic               tick;
    logic               pending;
    logic [FIELD_W-1:0] cur_field;
    phase_evt_t         evt;

    fracdiv_prescale #(
        .PRE_DIV (PRE_DIV)
    ) u_prescale (
        .clk       (clk),
        .rst       (rst),
        .gate_open (gate_open),
        .tick      (tick)
    );

    fracdiv_accum #(
        .FIELD_W (FIELD_W),
        .FRAC_W  (FRAC_W)
    ) u_accum (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .restart   (pending),
        .div_field (cur_field),
        .evt       (evt),
        .en_q      (clk_en_o)
    );

    fracdiv_ctrl #(
        .REG_W      (REG_W),
        .FIELD_LSB  (FIELD_LSB),
        .FIELD_W    (FIELD_W),
        .TRIG_BIT   (TRIG_BIT),
        .INIT_FIELD (INIT_FIELD)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .fire      (evt.fire),
        .cur_field (cur_field),
        .pending   (pending),
        .rd_data   (rd_data)
    );

    assert_clear_with_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(rd_data[TRIG_BIT]) |-> clk_en_o);

    assert_gate_closed_silent_R8: assert property (@(posedge clk) disable iff (rst)
        !gate_open |=> !clk_en_o);

endmodule

// File: tb/test_fracdiv_trig.sv
module test_fracdiv_trig;
    localparam int REG_W      = 32;
    localparam int FIELD_LSB  = 8;
    localparam int FIELD_W    = 6;
    localparam int FRAC_W     = 2;
    localparam int TRIG_BIT   = 0;
    localparam int PRE_DIV    = 2;
    localparam int INIT_FIELD = 4;
    localparam int ONE        = 1 << FRAC_W;
    localparam int MASK       = (1 << FIELD_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             gate_open = 1'b0;
    logic             wr_en = 1'b0;
    logic [REG_W-1:0] wr_data = '0;
    logic [REG_W-1:0] rd_data;
    logic             clk_en_o;

    always #10 clk = ~clk;

    fracdiv_trig #(
        .REG_W (REG_W), .FIELD_LSB (FIELD_LSB), .FIELD_W (FIELD_W),
        .FRAC_W (FRAC_W), .TRIG_BIT (TRIG_BIT), .PRE_DIV (PRE_DIV),
        .INIT_FIELD (INIT_FIELD)
    ) i_fracdiv_trig (
        .clk (clk), .rst (rst), .gate_open (gate_open), .wr_en (wr_en),
        .wr_data (wr_data), .rd_data (rd_data), .clk_en_o (clk_en_o)
    );

    int     n_chk = 0;
    int     n_fail = 0;
    string  tag = "R1";
    bit     running = 0;

    // independent expectation built from the requirement statements
    int     m_cur, m_stage, m_pre, m_d;
    bit     m_trig, m_en, m_tk, m_fi;
    longint m_t, m_p;

    always @(posedge clk) begin
        if (rst) begin
            m_cur = INIT_FIELD; m_stage = INIT_FIELD; m_trig = 0;
            m_pre = 0; m_t = 0; m_p = 0; m_en = 0;
        end else begin
            m_d  = m_cur + ONE;
            m_tk = gate_open && (m_pre == PRE_DIV - 1);
            if (gate_open) m_pre = (m_pre == PRE_DIV - 1) ? 0 : m_pre + 1;
            m_fi = 0;
            if (m_tk) begin
                m_t++;
                if (m_t * ONE >= (m_p + 1) * m_d) begin
                    m_fi = 1;
                    m_p++;
                end
            end
            m_en = m_fi;
            if (m_trig) begin
                if (m_fi) begin
                    m_cur = m_stage; m_trig = 0; m_t = 0; m_p = 0;
                end
            end else if (wr_en) begin
                m_stage = int'((wr_data >> FIELD_LSB) & MASK);
                if (wr_data[TRIG_BIT]) m_trig = 1;
            end
        end
    end

    task automatic chk(string r, longint got, longint exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0d expected %0d", r, got, exp);
        end
    endtask

    function automatic longint exp_rd();
        return (longint'(m_cur) << FIELD_LSB) | (longint'(m_trig) << TRIG_BIT);
    endfunction

    always @(negedge clk) begin
        if (running && !rst) begin
            chk({tag, " pulse"}, clk_en_o, m_en);
            chk({tag, " readback"}, rd_data, exp_rd());
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [REG_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_clear();
        for (int i = 0; i < 2000; i++) begin
            if (rd_data[TRIG_BIT] == 1'b0) break;
            @(negedge clk);
        end
    endtask

    task automatic count_pulses(int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (clk_en_o) cnt++;
        end
    endtask

    function automatic logic [REG_W-1:0] enc(int f, bit trg);
        return (REG_W'(f & MASK) << FIELD_LSB) | (REG_W'(trg) << TRIG_BIT);
    endfunction

    initial begin
        int cnt;
        void'($urandom(32'd20240611));
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset field", rd_data, enc(INIT_FIELD, 0));
        chk("R1 reset pulse", clk_en_o, 0);
        running = 1;
        gate_open = 1'b1;

        tag = "R2"; idle(60);

        tag = "R3"; wr(enc(0, 1)); wait_clear();
        count_pulses(40, cnt);
        chk("R3 unit divisor count", cnt, 20);

        tag = "R6"; wr(enc(9, 0)); idle(10);
        chk("R6 staged hidden", rd_data[FIELD_LSB +: FIELD_W], 0);

        tag = "R8"; gate_open = 1'b0; wr(enc(9, 1));
        count_pulses(50, cnt);
        chk("R8 no pulse while gated", cnt, 0);
        chk("R8 trigger pending", rd_data[TRIG_BIT], 1);
        gate_open = 1'b1;

        tag = "R9"; wr(enc(33, 1)); wait_clear();
        chk("R9 write while pending ignored", rd_data[FIELD_LSB +: FIELD_W], 9);
        idle(40);

        tag = "R4"; wr(enc(MASK, 1)); wait_clear();
        count_pulses(670, cnt);
        chk("R4 max divisor count", cnt, 20);

        tag = "R5"; wr(32'hFFFF_0000 | enc(5, 1) | 32'h0000_00F0); wait_clear();
        chk("R5 outside bits zero", rd_data & ~enc(MASK, 1), 0);
        chk("R5 field", rd_data[FIELD_LSB +: FIELD_W], 5);

        tag = "R7"; wr(enc(2, 1));
        chk("R7 trigger reads set", rd_data[TRIG_BIT], 1);
        wait_clear(); idle(30);

        tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            gate_open = ($urandom % 8) != 0;
            if (($urandom % 6) == 0) begin
                wr_en = 1'b1;
                wr_data = $urandom;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        idle(5);

        running = 0;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule